// File: doc/BRIEF.md
# Stream Compare-and-Splice Engine

After a playback stream has been interrupted and the source is re-read, this block finds the spot in the new stereo word stream where it lines up again with the data that was already confirmed as good. It holds the six most recent confirmed words (three left/right pairs) as a reference. It compares the incoming words against that reference and raises a one-cycle splice pulse. The write sequencer uses that pulse to resume writing at the valid write address.

A command carries a two-bit mode and a write-enable bit. Three modes start a sequence: strict, where every pair must match; lenient, where all pairs but one must match; and direct, where a fixed number of accepted words is enough and nothing is compared. The fourth mode code stops a running sequence. Every start is followed by a preparation interval, during which the reference is considered to be restored, and comparison then begins on a left-channel word. The reference is loaded through a small write port while the engine is idle.

Top module: `splice_engine`

## Requirements
- R1: After reset `busy_o` and `splice_o` are 0.
- R2: A command with mode 2'b11, 2'b10 or 2'b01 and write-enable 0 sets `busy_o` in the next cycle. Mode 2'b00 clears `busy_o`, and no splice follows later matching words.
- R3: A mode 2'b00 command while idle has no effect: `busy_o` stays 0 and no splice occurs.
- R4: A command with write-enable 1 clears `busy_o`, whatever its mode bits say, so it overrides a start given in the same command.
- R5: Reference word index 2p is the left word of pair p, and 2p+1 is its right word. Pair 0 is the oldest, so the stream must deliver index 0 first. Writes land only while `busy_o` is 0 and are ignored while it is 1.
- R6: Words presented during the PREP_CYCLES cycles that follow a start command are ignored.
- R7: After preparation, the first accepted word is a left word (`word_right_i`=0). Right words arriving before it are dropped.
- R8: Mode 2'b11 splices when the last six accepted words, ending with a right word, equal reference indices 0..5 in order. The window slides, so leading mismatches only delay the splice.
- R9: Mode 2'b10 splices at a right word when at least two of the three pairs in the window fully equal their reference pairs. A pair matches only when both its left and right words are equal.
- R10: Mode 2'b01 splices on the third accepted word with no comparison.
- R11: `splice_o` is a single-cycle pulse in the cycle after the completing word. `busy_o` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_mode_i | input | 2 | Sequence mode code |
| cmd_wren_i | input | 1 | Write-enable bit of the command |
| ref_we_i | input | 1 | Reference word write strobe |
| ref_idx_i | input | $clog2(2*NPAIRS) | Reference word index |
| ref_data_i | input | WORD_W | Reference word value |
| word_valid_i | input | 1 | Incoming stream word strobe |
| word_right_i | input | 1 | Incoming word channel: 0 left, 1 right |
| word_data_i | input | WORD_W | Incoming stream word |
| busy_o | output | 1 | Sequence in progress |
| splice_o | output | 1 | One-cycle resume-write pulse |

## Verification
The bench builds the engine with PREP_CYCLES=8 and keeps the default 16-bit words, three pairs and three-word direct splice. The short preparation lets a run send words exactly on the last ignored cycle and the first live cycle, so an off-by-one in the delay moves the splice by one cycle and the scoreboard catches it. It also leaves room to feed a full matching window during preparation and to confirm that none of it is kept.

// File: rtl/splice_pkg.sv
package splice_pkg;
  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_PAIR2  = 2'b10,
    MODE_PAIR3  = 2'b11
  } splice_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_ARMED,
    ST_RUN
  } splice_state_e;
endpackage

// File: rtl/splice_ref.sv
module splice_ref #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 6,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [WORD_W-1:0]              data_i,
  input  logic                           lock_i,
  output logic [NWORDS-1:0][WORD_W-1:0]  ref_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (we_i && !lock_i && idx_i == IDX_W'(g)) word_q <= data_i;
    end
    assign ref_o[g] = word_q;
  end

  AST_REF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(ref_o)); // R5
endmodule

// File: rtl/splice_window.sv
module splice_window #(
  parameter int WORD_W = 16,
  parameter int NPAIRS = 3,
  localparam int NWORDS = 2 * NPAIRS,
  localparam int CW = $clog2(NWORDS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic                           shift_i,
  input  logic [WORD_W-1:0]              data_i,
  input  logic [NWORDS-1:0][WORD_W-1:0]  ref_i,
  output logic [NPAIRS-1:0]              pair_hit_o,
  output logic [CW-1:0]                  fill_o
);
  // win_q[0] is the oldest held word; the incoming word completes the window
  logic [NWORDS-2:0][WORD_W-1:0] win_q;
  logic [NWORDS-1:0][WORD_W-1:0] cand;
  logic [CW-1:0]                 cnt_q;

  always_comb begin
    for (int k = 0; k < NWORDS - 1; k++) cand[k] = win_q[k];
    cand[NWORDS-1] = data_i;
  end

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign pair_hit_o[p] = (cand[2*p] == ref_i[2*p]) && (cand[2*p+1] == ref_i[2*p+1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      for (int k = 0; k < NWORDS - 2; k++) win_q[k] <= win_q[k+1];
      win_q[NWORDS-2] <= data_i;
      if (cnt_q != CW'(NWORDS)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fill_o = cnt_q;

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NWORDS)); // R8
  AST_FILL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0); // R6
endmodule

// File: rtl/splice_ctrl.sv
module splice_ctrl
  import splice_pkg::*;
#(
  parameter int NPAIRS       = 3,
  parameter int PREP_CYCLES  = 384,
  parameter int DIRECT_WORDS = 3,
  localparam int NWORDS = 2 * NPAIRS,
  localparam int CW     = $clog2(NWORDS + 1),
  localparam int PCW    = (PREP_CYCLES > 1) ? $clog2(PREP_CYCLES) : 1,
  localparam int LOOSE_NEED = NPAIRS - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  splice_mode_e       cmd_mode_i,
  input  logic               cmd_wren_i,
  input  logic               word_valid_i,
  input  logic               word_right_i,
  input  logic [NPAIRS-1:0]  pair_hit_i,
  input  logic [CW-1:0]      fill_i,
  output logic               win_clear_o,
  output logic               win_shift_o,
  output logic               busy_o,
  output logic               splice_o
);
  splice_state_e state_q;
  splice_mode_e  mode_q;
  logic [PCW-1:0] prep_q;
  logic          splice_q;
  logic          accept, hit, cmp_ok, start;

  assign start = cmd_valid_i && !cmd_wren_i && (cmd_mode_i != MODE_STOP);

  always_comb begin
    accept = word_valid_i && !cmd_valid_i &&
             ((state_q == ST_RUN) || (state_q == ST_ARMED && !word_right_i));
    cmp_ok = (mode_q == MODE_PAIR3) ? (&pair_hit_i)
                                    : ($countones(pair_hit_i) >= LOOSE_NEED);
    if (mode_q == MODE_DIRECT)
      hit = accept && (fill_i == CW'(DIRECT_WORDS - 1));
    else
      hit = accept && word_right_i && (fill_i >= CW'(NWORDS - 1)) && cmp_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_STOP;
      prep_q   <= '0;
      splice_q <= 1'b0;
    end else begin
      splice_q <= 1'b0;
      if (cmd_valid_i) begin
        if (start) begin
          state_q <= ST_PREP;
          mode_q  <= cmd_mode_i;
          prep_q  <= PCW'(PREP_CYCLES - 1);
        end else begin
          state_q <= ST_IDLE;  // write-enable or stop
        end
      end else begin
        unique case (state_q)
          ST_PREP: begin
            if (prep_q == '0) state_q <= ST_ARMED;
            else prep_q <= prep_q - 1'b1;
          end
          ST_ARMED, ST_RUN: begin
            if (hit) begin
              state_q  <= ST_IDLE;
              splice_q <= 1'b1;
            end else if (accept) begin
              state_q <= ST_RUN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign win_clear_o = start;
  assign win_shift_o = accept;
  assign busy_o      = (state_q != ST_IDLE);
  assign splice_o    = splice_q;

  AST_SPLICE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    splice_o |=> !splice_o); // R11
  AST_SPLICE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    splice_o |-> !busy_o && $past(busy_o)); // R11
  AST_WREN_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_wren_i |=> !busy_o && !splice_o); // R4
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o); // R2
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_wren_i && cmd_mode_i == MODE_STOP |=> !busy_o && !splice_o); // R3
  AST_PREP_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PREP |-> !win_shift_o); // R6
endmodule

// File: rtl/splice_engine.sv
module splice_engine
  import splice_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int NPAIRS       = 3,
  parameter int PREP_CYCLES  = 384,
  parameter int DIRECT_WORDS = 3,
  localparam int NWORDS = 2 * NPAIRS,
  localparam int IDX_W  = $clog2(NWORDS),
  localparam int CW     = $clog2(NWORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_mode_i,
  input  logic              cmd_wren_i,
  input  logic              ref_we_i,
  input  logic [IDX_W-1:0]  ref_idx_i,
  input  logic [WORD_W-1:0] ref_data_i,
  input  logic              word_valid_i,
  input  logic              word_right_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              busy_o,
  output logic              splice_o
);
  logic [NWORDS-1:0][WORD_W-1:0] ref_words;
  logic [NPAIRS-1:0]             pair_hit;
  logic [CW-1:0]                 fill;
  logic                          win_clear, win_shift, busy;

  splice_ref #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ref_we_i),
    .idx_i  (ref_idx_i),
    .data_i (ref_data_i),
    .lock_i (busy),
    .ref_o  (ref_words)
  );

  splice_window #(.WORD_W(WORD_W), .NPAIRS(NPAIRS)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (win_clear),
    .shift_i    (win_shift),
    .data_i     (word_data_i),
    .ref_i      (ref_words),
    .pair_hit_o (pair_hit),
    .fill_o     (fill)
  );

  splice_ctrl #(.NPAIRS(NPAIRS), .PREP_CYCLES(PREP_CYCLES), .DIRECT_WORDS(DIRECT_WORDS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_mode_i   (splice_mode_e'(cmd_mode_i)),
    .cmd_wren_i   (cmd_wren_i),
    .word_valid_i (word_valid_i),
    .word_right_i (word_right_i),
    .pair_hit_i   (pair_hit),
    .fill_i       (fill),
    .win_clear_o  (win_clear),
    .win_shift_o  (win_shift),
    .busy_o       (busy),
    .splice_o     (splice_o)
  );

  assign busy_o = busy;
endmodule

// File: tb/sim_splice_engine.sv
`timescale 1ns/1ps
module sim_splice_engine;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_wren = 0, ref_we = 0, word_valid = 0, word_right = 0;
  logic [1:0] cmd_mode = '0;
  logic [2:0] ref_idx = '0;
  logic [W-1:0] ref_data = '0, word_data = '0;
  logic busy, splice;

  int cyc = 0, checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  logic [W-1:0] refv [6] = '{16'h1100, 16'h2200, 16'h3300, 16'h4400, 16'h5500, 16'h6600};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  splice_engine #(.WORD_W(W), .NPAIRS(3), .PREP_CYCLES(8), .DIRECT_WORDS(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_mode_i(cmd_mode),
    .cmd_wren_i(cmd_wren), .ref_we_i(ref_we), .ref_idx_i(ref_idx), .ref_data_i(ref_data),
    .word_valid_i(word_valid), .word_right_i(word_right), .word_data_i(word_data),
    .busy_o(busy), .splice_o(splice));

  // monitor: every splice must match the head of the expected queue
  always @(negedge clk) if (rst_n && splice) begin
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected splice at cycle %0d (expected none)", cyc);
    end else if (exp_q[0] != cyc) begin
      fails++;
      $display("FAIL %s splice at cycle %0d, expected cycle %0d", tag_q[0], cyc, exp_q[0]);
    end else begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic slot();
    @(posedge clk); #1;
    cmd_valid = 0; word_valid = 0; ref_we = 0; cmd_wren = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) slot();
  endtask

  task automatic cmd(logic [1:0] m, logic wr);
    slot(); cmd_valid = 1; cmd_mode = m; cmd_wren = wr;
  endtask

  task automatic ref_wr(int idx, logic [W-1:0] d);
    slot(); ref_we = 1; ref_idx = 3'(idx); ref_data = d;
  endtask

  task automatic word(logic [W-1:0] d, logic r, bit expect_splice = 0, string tag = "");
    slot(); word_valid = 1; word_data = d; word_right = r;
    if (expect_splice) begin
      exp_q.push_back(cyc + 1);
      tag_q.push_back(tag);
    end
  endtask

  task automatic ref_stream(bit expect_splice, string tag);
    for (int i = 0; i < 6; i++) word(refv[i], i[0], expect_splice && i == 5, tag);
  endtask

  task automatic check_busy(logic e, string tag);
    slot(); @(negedge clk);
    checks++;
    if (busy !== e) begin
      fails++;
      $display("FAIL %s busy_o=%0b expected %0b", tag, busy, e);
    end
  endtask

  task automatic drained(string tag);
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s missing splice, expected at cycle %0d, got none", tag, exp_q[0]);
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || splice !== 1'b0) begin
      fails++;
      $display("FAIL R1 busy/splice=%0b%0b expected 00", busy, splice);
    end

    for (int i = 0; i < 6; i++) ref_wr(i, refv[i]); // R5 load while idle

    // R3: stop while idle
    cmd(2'b00, 0);
    check_busy(0, "R3");
    ref_stream(0, "R3");
    drained("R3");

    // R2: start then stop
    cmd(2'b11, 0);
    check_busy(1, "R2 start");
    cmd(2'b00, 0);
    check_busy(0, "R2 stop");
    idle(10);
    ref_stream(0, "R2");
    drained("R2");

    // R4: write-enable overrides start, and cancels a running sequence
    cmd(2'b11, 1);
    check_busy(0, "R4 override");
    cmd(2'b10, 0);
    check_busy(1, "R4 start");
    cmd(2'b10, 1);
    check_busy(0, "R4 cancel");
    idle(10);
    ref_stream(0, "R4");
    drained("R4");

    // R6 + R8: full match during prep ignored, sliding 3-pair match later
    cmd(2'b11, 0);
    ref_stream(0, "R6");
    idle(2);
    word(refv[0], 0); word(refv[1], 1); word(16'h0aaa, 0); word(16'h0bbb, 1);
    word(refv[4], 0); word(refv[5], 1);
    ref_stream(1, "R8");
    check_busy(0, "R11 busy after splice");
    drained("R8");

    // R5: write ignored while busy
    cmd(2'b11, 0);
    ref_wr(0, 16'hdead);
    idle(10);
    ref_stream(1, "R5 frozen");
    drained("R5 frozen");

    // R5: write while idle takes effect
    ref_wr(5, 16'h7700);
    cmd(2'b11, 0);
    idle(10);
    ref_stream(0, "R5 old value");
    for (int i = 0; i < 6; i++) word(i == 5 ? 16'h7700 : refv[i], i[0], i == 5, "R5 new value");
    drained("R5 new value");
    ref_wr(5, refv[5]);

    // R9: lenient mode; one full pair is not enough, left-only hits do not count
    cmd(2'b10, 0);
    idle(10);
    word(refv[0], 0); word(refv[1], 1); word(refv[2], 0); word(16'h9999, 1);
    word(refv[4], 0); word(16'h9999, 1);
    word(refv[0], 0); word(refv[1], 1); word(16'h8888, 0); word(16'h7777, 1);
    word(refv[4], 0); word(refv[5], 1, 1, "R9");
    drained("R9");

    // R10 + R7 + R6 boundary: direct splice on third accepted word
    cmd(2'b01, 0);
    idle(7);
    word(16'h0001, 0);                // last prep cycle: ignored (R6)
    word(16'h0002, 1);                // right before first left: dropped (R7)
    word(16'h0003, 0);
    word(16'h0004, 1);
    word(16'h0005, 0, 1, "R10/R7");
    check_busy(0, "R10 busy after splice");
    drained("R10");

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule